// File: doc/BRIEF.md
# Image Resampling Address Sequencer

This block produces addresses for one axis of a resampling engine built from two copies. A row copy and a column copy each walk a source image through short interpolation runs. Each run is called a walk. During a walk the block issues a source address and a coefficient address on every cycle. A single target address names the result slot for that walk. Two strobes drive an external multiply-accumulate unit. An active-low accumulate-clear goes low on the first sample of each walk, and an active-low target write goes low in the cycle right after the last sample.

Parameters are double-buffered. Software writes sixteen 12-bit preload slots one at a time. A load pulse then copies all of them into the working set in a single cycle, so a running sequence never sees a half-updated set. The two copies are cross-linked. The row copy's end-of-line flag paces the column copy. The column copy's end-of-frame flag, returned to the row copy, forces the row counters back to the start. A hold input freezes all counters and releases the source and coefficient buses. A high-impedance control releases the write strobe. Both are modelled as output-enable pins.

All pins are plain control and address pins. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `resample_addr_seq`

## Requirements
- R1: While `rst_n` is low: `acc_clr_n`=1, `tgt_wr_n`=1, `link_end`=0, all addresses are 0, `src_oe`=`coef_oe`=1 and `tgt_wr_oe`=0. After reset no walk starts until a valid INIT has been given.
- R2: Every input is captured on the rising edge. A captured `prm_wr_n`=0 writes `prm_data` into preload slot `prm_sel` at the next edge. A captured `prm_wr_n`=1 leaves all preload slots unchanged.
- R3: A captured `bank_load`=1 copies all sixteen preload slots into the working slots at the next edge. While the captured `bank_load` is 0, the working slots keep their values.
- R4: `init_req` sampled high on two consecutive edges clears the sequencer. The first walk's accumulate-clear then appears after the third rising edge that follows the first edge sampling `init_req` low. If `init_req` is high for only one edge, sequencing stops and stays stopped.
- R5: The working slots are used as follows: 0 holds the walk length L (0 acts as 1), 1 the source start, 2 the in-walk source step, 3 the per-walk base advance, 4 the coefficient start (bits 7:0), and 5 the line count N (0 acts as 1). Sample p of walk w in a line has source address (start + w·advance + p·step) mod 4096 and coefficient address (coefficient start + p) mod 256.
- R6: `acc_clr_n` is low for exactly the first sample cycle of each walk and is never low together with `tgt_wr_n`.
- R7: `tgt_wr_n` is low for exactly one cycle, the cycle right after the last sample of a walk. Each walk therefore takes L+1 cycles, and in row mode the next walk starts immediately.
- R8: `tgt_addr` equals the walk index within the line. `link_end` is high together with the write strobe of walk N−1. After that walk the target index and the walk base return to 0 and to the source start.
- R9: Row mode (COL_AXIS=0): a captured `link_in`=1 while walking aborts the walk. After the second edge from the one that sampled it, a new walk starts with the source start, coefficient start, target 0 and `acc_clr_n`=0.
- R10: Column mode (COL_AXIS=1): the first walk follows INIT. Every later walk waits for a captured `link_in`=1 and starts after the second edge from the one that sampled it.
- R11: A captured `hold_n`=0 drives `src_oe` and `coef_oe` low. From the following edge all addresses and counters hold, and `acc_clr_n` and `tgt_wr_n` stay high. After release the walk resumes where it stopped.
- R12: `tgt_wr_oe` is the inverse of the captured `wr_hiz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| prm_data | input | 12 | preload write data |
| prm_sel | input | 4 | preload slot select |
| prm_wr_n | input | 1 | preload write enable, active low |
| bank_load | input | 1 | copy preload set to working set |
| init_req | input | 1 | sequencer initialise request |
| hold_n | input | 1 | freeze counters, active low |
| wr_hiz | input | 1 | release the target write strobe |
| link_in | input | 1 | end flag from the partner copy |
| src_addr | output | 12 | source address |
| src_oe | output | 1 | source address drive enable |
| coef_addr | output | 8 | coefficient address |
| coef_oe | output | 1 | coefficient address drive enable |
| tgt_addr | output | 12 | target address |
| acc_clr_n | output | 1 | accumulator restart strobe, active low |
| tgt_wr_n | output | 1 | target write strobe, active low |
| tgt_wr_oe | output | 1 | target write strobe drive enable |
| link_end | output | 1 | end-of-line or end-of-frame flag |

## Verification
The bench targets these boundary cases:
- Walk lengths and line counts of zero. A design that took them literally would underflow and run a 4096-sample walk.
- A source start near the top of the address range. A design that did not wrap modulo 4096 would show a wrong address after wrapping.
- A write while `prm_wr_n` is high, and a preload change with no load pulse. A design that missed either would start walks from the new source start.
- A single-cycle INIT. A design that accepted it would resume walking.
- A hold in mid-walk. A design that failed to hold would move the source bus or skip a step on release.
- A row abort on `link_in`, and a column copy paced by the row copy's end flag. Any extra or missing pipeline stage moves the accumulate-clear by one cycle and is caught.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    ST_HALT,
    ST_ARM,
    ST_WAIT,
    ST_WALK,
    ST_GAP,
    ST_LINE
  } seq_state_t;

  localparam int IDX_LEN   = 0;
  localparam int IDX_SRC0  = 1;
  localparam int IDX_STEP  = 2;
  localparam int IDX_ADV   = 3;
  localparam int IDX_COEF0 = 4;
  localparam int IDX_LINE  = 5;
  localparam int NUM_USED  = 6;
endpackage

// File: rtl/rsq_in_reg.sv
module rsq_in_reg #(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] prm_data,
  input  logic [AW-1:0] prm_sel,
  input  logic          prm_wr_n,
  input  logic          bank_load,
  input  logic          init_req,
  input  logic          hold_n,
  input  logic          wr_hiz,
  input  logic          link_in,
  output logic [DW-1:0] r_data,
  output logic [AW-1:0] r_sel,
  output logic          r_wr_n,
  output logic          r_load,
  output logic          r_init,
  output logic          r_hold_n,
  output logic          r_hiz,
  output logic          r_link
);
  // every pin is captured before any logic looks at it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_data   <= '0;
      r_sel    <= '0;
      r_wr_n   <= 1'b1;
      r_load   <= 1'b0;
      r_init   <= 1'b0;
      r_hold_n <= 1'b1;
      r_hiz    <= 1'b1;
      r_link   <= 1'b0;
    end else begin
      r_data   <= prm_data;
      r_sel    <= prm_sel;
      r_wr_n   <= prm_wr_n;
      r_load   <= bank_load;
      r_init   <= init_req;
      r_hold_n <= hold_n;
      r_hiz    <= wr_hiz;
      r_link   <= link_in;
    end
  end
endmodule

// File: rtl/rsq_param_bank.sv
module rsq_param_bank #(
  parameter int DW = 12,
  parameter int AW = 4,
  localparam int NREG = 1 << AW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_n,
  input  logic                      load,
  input  logic [AW-1:0]             sel,
  input  logic [DW-1:0]             data,
  output logic [NREG-1:0][DW-1:0]   work
);
  logic [DW-1:0] pre_q  [NREG];
  logic [DW-1:0] work_q [NREG];

  // shadow set written slot by slot, working set swapped as a whole
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        pre_q[i]  <= '0;
        work_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (!wr_n && (sel == AW'(i))) pre_q[i] <= data;
        if (load) work_q[i] <= pre_q[i];
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign work[g] = work_q[g];
  end
endmodule

// File: rtl/rsq_walk_ctrl.sv
module rsq_walk_ctrl
  import rsq_pkg::*;
#(
  parameter int DW       = 12,
  parameter int CW       = 8,
  parameter bit COL_AXIS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          hold_n_i,
  input  logic          link_i,
  input  logic [DW-1:0] len_i,
  input  logic [DW-1:0] src0_i,
  input  logic [DW-1:0] step_i,
  input  logic [DW-1:0] adv_i,
  input  logic [CW-1:0] coef0_i,
  input  logic [DW-1:0] line_i,
  output logic [DW-1:0] src_o,
  output logic [CW-1:0] coef_o,
  output logic [DW-1:0] tgt_o,
  output logic          begin_walk_o,
  output logic          enter_gap_o,
  output logic          line_end_o
);
  localparam bit ROW = !COL_AXIS;

  seq_state_t    st_q, st_d;
  logic [1:0]    icnt_q, icnt_d;
  logic          wcnt_q, wcnt_d;
  logic [DW-1:0] pos_q, pos_d;
  logic [DW-1:0] src_q, src_d;
  logic [DW-1:0] base_q, base_d;
  logic [CW-1:0] coef_q, coef_d;
  logic [DW-1:0] tgt_q, tgt_d;
  logic [DW-1:0] nxt_base;
  logic          last_smp, last_walk, walking;

  // zero counts compare as one: the compare runs one bit wider
  assign last_smp  = ({1'b0, pos_q} + {{DW{1'b0}}, 1'b1}) >= {1'b0, len_i};
  assign last_walk = ({1'b0, tgt_q} + {{DW{1'b0}}, 1'b1}) >= {1'b0, line_i};
  assign walking   = (st_q == ST_WALK) || (st_q == ST_GAP) || (st_q == ST_LINE);
  assign nxt_base  = last_walk ? src0_i : (base_q + adv_i);

  always_comb begin
    st_d         = st_q;
    icnt_d       = icnt_q;
    wcnt_d       = wcnt_q;
    pos_d        = pos_q;
    src_d        = src_q;
    base_d       = base_q;
    coef_d       = coef_q;
    tgt_d        = tgt_q;
    begin_walk_o = 1'b0;
    enter_gap_o  = 1'b0;
    line_end_o   = 1'b0;
    if (init_i) begin
      // second consecutive init edge arms the sequencer
      icnt_d = (icnt_q == 2'd2) ? 2'd2 : icnt_q + 2'd1;
      st_d   = (icnt_q != 2'd0) ? ST_ARM : ST_HALT;
      wcnt_d = 1'b0;
      pos_d  = '0;
      src_d  = '0;
      base_d = '0;
      coef_d = '0;
      tgt_d  = '0;
    end else begin
      icnt_d = 2'd0;
      if (!hold_n_i) begin
        st_d = st_q;
      end else if (ROW && link_i && walking) begin
        // bottom of frame from the partner: restart the line
        st_d         = ST_WALK;
        pos_d        = '0;
        src_d        = src0_i;
        base_d       = src0_i;
        coef_d       = coef0_i;
        tgt_d        = '0;
        begin_walk_o = 1'b1;
      end else begin
        case (st_q)
          ST_ARM: begin
            st_d   = ST_WAIT;
            wcnt_d = 1'b0;
          end
          ST_WAIT: begin
            if (wcnt_q) begin
              st_d         = ST_WALK;
              pos_d        = '0;
              src_d        = src0_i;
              base_d       = src0_i;
              coef_d       = coef0_i;
              tgt_d        = '0;
              begin_walk_o = 1'b1;
            end else begin
              wcnt_d = 1'b1;
            end
          end
          ST_WALK: begin
            if (last_smp) begin
              st_d        = ST_GAP;
              enter_gap_o = 1'b1;
              line_end_o  = last_walk;
            end else begin
              pos_d  = pos_q + {{(DW-1){1'b0}}, 1'b1};
              src_d  = src_q + step_i;
              coef_d = coef_q + {{(CW-1){1'b0}}, 1'b1};
            end
          end
          ST_GAP: begin
            base_d = nxt_base;
            tgt_d  = last_walk ? '0 : tgt_q + {{(DW-1){1'b0}}, 1'b1};
            if (COL_AXIS) begin
              st_d = ST_LINE;
            end else begin
              st_d         = ST_WALK;
              pos_d        = '0;
              src_d        = nxt_base;
              coef_d       = coef0_i;
              begin_walk_o = 1'b1;
            end
          end
          ST_LINE: begin
            if (link_i) begin
              st_d         = ST_WALK;
              pos_d        = '0;
              src_d        = base_q;
              coef_d       = coef0_i;
              begin_walk_o = 1'b1;
            end
          end
          default: st_d = st_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HALT;
      icnt_q <= 2'd0;
      wcnt_q <= 1'b0;
      pos_q  <= '0;
      src_q  <= '0;
      base_q <= '0;
      coef_q <= '0;
      tgt_q  <= '0;
    end else begin
      st_q   <= st_d;
      icnt_q <= icnt_d;
      wcnt_q <= wcnt_d;
      pos_q  <= pos_d;
      src_q  <= src_d;
      base_q <= base_d;
      coef_q <= coef_d;
      tgt_q  <= tgt_d;
    end
  end

  assign src_o  = src_q;
  assign coef_o = coef_q;
  assign tgt_o  = tgt_q;
endmodule

// File: rtl/rsq_strobe_reg.sv
module rsq_strobe_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic begin_walk,
  input  logic enter_gap,
  input  logic line_end,
  input  logic r_hold_n,
  input  logic r_hiz,
  output logic acc_clr_n,
  output logic tgt_wr_n,
  output logic link_end,
  output logic src_oe,
  output logic coef_oe,
  output logic tgt_wr_oe
);
  // strobes change on the same edge as the state they describe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_clr_n <= 1'b1;
      tgt_wr_n  <= 1'b1;
      link_end  <= 1'b0;
    end else begin
      acc_clr_n <= !begin_walk;
      tgt_wr_n  <= !enter_gap;
      link_end  <= line_end;
    end
  end

  assign src_oe    = r_hold_n;
  assign coef_oe   = r_hold_n;
  assign tgt_wr_oe = !r_hiz;
endmodule

// File: rtl/resample_addr_seq.sv
module resample_addr_seq
  import rsq_pkg::*;
#(
  parameter int DW       = 12,
  parameter int AW       = 4,
  parameter int CW       = 8,
  parameter bit COL_AXIS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] prm_data,
  input  logic [AW-1:0] prm_sel,
  input  logic          prm_wr_n,
  input  logic          bank_load,
  input  logic          init_req,
  input  logic          hold_n,
  input  logic          wr_hiz,
  input  logic          link_in,
  output logic [DW-1:0] src_addr,
  output logic          src_oe,
  output logic [CW-1:0] coef_addr,
  output logic          coef_oe,
  output logic [DW-1:0] tgt_addr,
  output logic          acc_clr_n,
  output logic          tgt_wr_n,
  output logic          tgt_wr_oe,
  output logic          link_end
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0]           r_data;
  logic [AW-1:0]           r_sel;
  logic                    r_wr_n, r_load, r_init, r_hold_n, r_hiz, r_link;
  logic [NREG-1:0][DW-1:0] work;
  logic                    begin_walk, enter_gap, line_end;
  logic                    unused_par;

  rsq_in_reg #(.DW(DW), .AW(AW)) u_in (
    .clk(clk), .rst_n(rst_n),
    .prm_data(prm_data), .prm_sel(prm_sel), .prm_wr_n(prm_wr_n),
    .bank_load(bank_load), .init_req(init_req), .hold_n(hold_n),
    .wr_hiz(wr_hiz), .link_in(link_in),
    .r_data(r_data), .r_sel(r_sel), .r_wr_n(r_wr_n), .r_load(r_load),
    .r_init(r_init), .r_hold_n(r_hold_n), .r_hiz(r_hiz), .r_link(r_link)
  );

  rsq_param_bank #(.DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_n(r_wr_n), .load(r_load), .sel(r_sel), .data(r_data),
    .work(work)
  );

  rsq_walk_ctrl #(.DW(DW), .CW(CW), .COL_AXIS(COL_AXIS)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .init_i(r_init), .hold_n_i(r_hold_n), .link_i(r_link),
    .len_i(work[IDX_LEN]), .src0_i(work[IDX_SRC0]), .step_i(work[IDX_STEP]),
    .adv_i(work[IDX_ADV]), .coef0_i(work[IDX_COEF0][CW-1:0]),
    .line_i(work[IDX_LINE]),
    .src_o(src_addr), .coef_o(coef_addr), .tgt_o(tgt_addr),
    .begin_walk_o(begin_walk), .enter_gap_o(enter_gap), .line_end_o(line_end)
  );

  rsq_strobe_reg u_strb (
    .clk(clk), .rst_n(rst_n),
    .begin_walk(begin_walk), .enter_gap(enter_gap), .line_end(line_end),
    .r_hold_n(r_hold_n), .r_hiz(r_hiz),
    .acc_clr_n(acc_clr_n), .tgt_wr_n(tgt_wr_n), .link_end(link_end),
    .src_oe(src_oe), .coef_oe(coef_oe), .tgt_wr_oe(tgt_wr_oe)
  );

  // spare working slots are stored but steer nothing
  assign unused_par = ^{work[NREG-1:NUM_USED], work[IDX_COEF0][DW-1:CW]};
endmodule

// File: rtl/resample_addr_seq_chk.sv
module resample_addr_seq_chk #(
  parameter int DW = 12,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_req,
  input logic          wr_hiz,
  input logic [DW-1:0] src_addr,
  input logic          src_oe,
  input logic [CW-1:0] coef_addr,
  input logic [DW-1:0] tgt_addr,
  input logic          acc_clr_n,
  input logic          tgt_wr_n,
  input logic          tgt_wr_oe,
  input logic          link_end
);
  assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_wr_n |=> tgt_wr_n);

  assert_acc_wr_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!acc_clr_n && !tgt_wr_n));

  assert_end_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_end |-> !tgt_wr_n);

  assert_hold_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_oe && $past(!src_oe) && !$past(init_req, 2)) |->
      ($stable(src_addr) && $stable(coef_addr) && $stable(tgt_addr)));

  assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_oe && $past(!src_oe)) |-> (acc_clr_n && tgt_wr_n && !link_end));

  assert_hiz_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_hiz) |=> !tgt_wr_oe);
endmodule

bind resample_addr_seq resample_addr_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .wr_hiz(wr_hiz),
  .src_addr(src_addr), .src_oe(src_oe), .coef_addr(coef_addr),
  .tgt_addr(tgt_addr), .acc_clr_n(acc_clr_n), .tgt_wr_n(tgt_wr_n),
  .tgt_wr_oe(tgt_wr_oe), .link_end(link_end)
);

// File: tb/sim_resample_addr_seq.sv
module sim_resample_addr_seq;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] prm_data = '0;
  logic [3:0]  prm_sel = '0;
  logic        prm_wr_n = 1'b1;
  logic        bank_load = 1'b0;
  logic        init_req = 1'b0;
  logic        hold_n = 1'b1;
  logic        wr_hiz = 1'b0;
  logic        link_in = 1'b0;

  logic [11:0] src_addr, tgt_addr;
  logic [7:0]  coef_addr;
  logic        src_oe, coef_oe, acc_clr_n, tgt_wr_n, tgt_wr_oe, link_end;
  logic [11:0] c_src, c_tgt;
  logic [7:0]  c_coef;
  logic        c_src_oe, c_coef_oe, c_acc, c_wr, c_wr_oe, c_end;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // walk configs: length, src start, step, advance, coef start, line count
  localparam logic [11:0] VEC [3][6] = '{
    '{12'd3, 12'h100, 12'd2, 12'd5, 12'h010, 12'd3},
    '{12'd1, 12'hFFE, 12'd3, 12'd7, 12'h0F0, 12'd2},
    '{12'd0, 12'h040, 12'd1, 12'd9, 12'h0FF, 12'd0}
  };

  always #10 clk = ~clk;

  resample_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .prm_data(prm_data), .prm_sel(prm_sel),
    .prm_wr_n(prm_wr_n), .bank_load(bank_load), .init_req(init_req),
    .hold_n(hold_n), .wr_hiz(wr_hiz), .link_in(link_in),
    .src_addr(src_addr), .src_oe(src_oe), .coef_addr(coef_addr),
    .coef_oe(coef_oe), .tgt_addr(tgt_addr), .acc_clr_n(acc_clr_n),
    .tgt_wr_n(tgt_wr_n), .tgt_wr_oe(tgt_wr_oe), .link_end(link_end)
  );

  // column copy paced by the row copy's end flag
  resample_addr_seq #(.COL_AXIS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .prm_data(prm_data), .prm_sel(prm_sel),
    .prm_wr_n(prm_wr_n), .bank_load(bank_load), .init_req(init_req),
    .hold_n(hold_n), .wr_hiz(wr_hiz), .link_in(link_end),
    .src_addr(c_src), .src_oe(c_src_oe), .coef_addr(c_coef),
    .coef_oe(c_coef_oe), .tgt_addr(c_tgt), .acc_clr_n(c_acc),
    .tgt_wr_n(c_wr), .tgt_wr_oe(c_wr_oe), .link_end(c_end)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [11:0] val, input logic wn);
    prm_sel  = 4'(idx);
    prm_data = val;
    prm_wr_n = wn;
    @(negedge clk);
    prm_wr_n = 1'b1;
  endtask

  task automatic load_bank();
    bank_load = 1'b1;
    @(negedge clk);
    bank_load = 1'b0;
    @(negedge clk);
  endtask

  // leaves the bench at the sample point of the first walk cycle
  task automatic start_run();
    init_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    init_req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [11:0] le, ne, base, r;
    int w, p, wl, cnt;
    bit h1, h2;

    // R1 reset state
    @(negedge clk);
    chk("R1 acc", acc_clr_n, 1);
    chk("R1 wr", tgt_wr_n, 1);
    chk("R1 end", link_end, 0);
    chk("R1 addrs", {src_addr, tgt_addr, coef_addr}, 0);
    chk("R1 oe", {src_oe, coef_oe, tgt_wr_oe}, 3'b110);
    rst_n = 1'b1;
    cnt = 0;
    repeat (12) begin
      @(negedge clk);
      if (!acc_clr_n) cnt++;
    end
    chk("R1 no walk before init", cnt, 0);

    // table walk: R2 R3 R5 R6 R7 R8 R10
    for (int v = 0; v < 3; v++) begin
      for (int i = 0; i < 6; i++) wr_reg(i, VEC[v][i], 1'b0);
      load_bank();
      start_run();
      le = (VEC[v][0] == 0) ? 12'd1 : VEC[v][0];
      ne = (VEC[v][5] == 0) ? 12'd1 : VEC[v][5];
      h1 = 1'b0;
      h2 = 1'b0;
      for (int c = 0; c < 2 * int'(ne) * (int'(le) + 1) + 2; c++) begin
        w  = c / (int'(le) + 1);
        p  = c % (int'(le) + 1);
        wl = w % int'(ne);
        base = 12'(VEC[v][1] + 12'(wl) * VEC[v][3]);
        chk("R8 tgt index", tgt_addr, 12'(wl));
        if (p < int'(le)) begin
          chk("R5 src addr", src_addr, 12'(base + 12'(p) * VEC[v][2]));
          chk("R5 coef addr", coef_addr, 8'(VEC[v][4][7:0] + 8'(p)));
          chk("R6 acc first sample", acc_clr_n, (p != 0));
          chk("R7 no write in walk", tgt_wr_n, 1);
          chk("R8 end low", link_end, 0);
        end else begin
          chk("R7 write after walk", tgt_wr_n, 0);
          chk("R6 acc high in gap", acc_clr_n, 1);
          chk("R8 end at line", link_end, (wl == int'(ne) - 1));
        end
        if (v == 0) chk("R10 column pacing", c_acc, !(c == 0 || h2));
        h2 = h1;
        h1 = link_end;
        @(negedge clk);
      end
    end

    // R2 write with enable high is ignored
    wr_reg(1, 12'hABC, 1'b1);
    load_bank();
    start_run();
    chk("R2 disabled write", src_addr, VEC[2][1]);
    // R3 preload change without load leaves working set
    wr_reg(1, 12'h321, 1'b0);
    start_run();
    chk("R3 no load", src_addr, VEC[2][1]);
    load_bank();
    start_run();
    chk("R3 load copies", src_addr, 12'h321);

    for (int i = 0; i < 6; i++) wr_reg(i, VEC[0][i], 1'b0);
    load_bank();
    start_run();

    // R4 single-cycle init halts
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    repeat (2) @(negedge clk);
    cnt = 0;
    repeat (15) begin
      @(negedge clk);
      if (!acc_clr_n) cnt++;
    end
    chk("R4 short init halts", cnt, 0);
    start_run();
    chk("R4 restart acc", acc_clr_n, 0);
    chk("R4 restart src", src_addr, 12'h100);

    // R11 hold
    hold_n = 1'b0;
    @(negedge clk);
    chk("R11 src oe low", src_oe, 0);
    chk("R11 coef oe low", coef_oe, 0);
    r = src_addr;
    chk("R11 last step before hold", r, 12'h102);
    repeat (3) begin
      @(negedge clk);
      chk("R11 src held", src_addr, r);
      chk("R11 strobes quiet", {acc_clr_n, tgt_wr_n}, 2'b11);
    end
    hold_n = 1'b1;
    @(negedge clk);
    chk("R11 oe back", src_oe, 1);
    chk("R11 still held", src_addr, 12'h102);
    @(negedge clk);
    chk("R11 resume", src_addr, 12'h104);

    // R9 row abort on link_in
    start_run();
    repeat (5) @(negedge clk);
    chk("R9 pre abort tgt", tgt_addr, 1);
    link_in = 1'b1;
    @(negedge clk);
    link_in = 1'b0;
    @(negedge clk);
    chk("R9 abort acc", acc_clr_n, 0);
    chk("R9 abort src", src_addr, 12'h100);
    chk("R9 abort tgt", tgt_addr, 0);
    chk("R9 abort coef", coef_addr, 8'h10);

    // R12 write strobe release
    wr_hiz = 1'b1;
    @(negedge clk);
    chk("R12 released", tgt_wr_oe, 0);
    wr_hiz = 1'b0;
    @(negedge clk);
    chk("R12 driven", tgt_wr_oe, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule